// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests from 24 sources and presents at most one of them to a single processor. The sources are 16 external lines, an I2C unit, two DMA channels, a message unit and four global timers. Each source carries its own programmable vector, 4-bit priority, mask bit and destination bit. A request is accepted only from an unmasked source with a priority above zero. Accepted requests wait as pending until the arbiter selects them.

When nothing is in service, the arbiter picks the pending source with the highest priority and takes it. Taking a source marks it active, latches its vector and raises the processor interrupt line. Software reads the acknowledge register to get the vector. It then writes the end-of-interrupt register, which retires the source and lets the next pending source be taken on the same clock edge. Registers sit on a plain 32-bit bus addressed by word: the word address is the byte offset divided by four. Reads are combinational and have no side effects.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every source reads masked with priority, vector, destination and active all zero (vector/priority word reads 0x80000000). Nothing is pending or in service, `irq_o` is low and the spurious vector is 0.
- R2: A source's vector/priority word holds the mask in bit 31, a read-only active flag in bit 30, the priority in bits 19:16 and the vector in bits 7:0. Other bits read zero. A destination word stores only bit 0.
- R3: Byte offsets: source n (n = 0..19; 16 is I2C, 17 and 18 are DMA, 19 is the message unit) has its vector/priority word at 0x50200 + 0x20·n and its destination word at 0x10 above that. Timer t (source 20+t) has its vector/priority word at 0x41120 + 0x40·t and its destination word at 0x41130 + 0x40·t.
- R4: A request becomes pending only if, in the cycle it is presented, its source is unmasked and has a nonzero priority. Otherwise it is discarded, and later unmasking does not revive it.
- R5: Among pending sources the highest priority is taken. When priorities are equal, the higher source number is taken.
- R6: A source is taken only while nothing is in service. `irq_o` is high from the take until end-of-interrupt, and a higher-priority request that arrives meanwhile does not preempt.
- R7: A read of the acknowledge word (0x600A0) returns the taken source's vector while one is in service. Otherwise it returns the 8-bit spurious vector held at 0x410E0.
- R8: Any write to the end-of-interrupt word (0x600B0) clears the active flag of the in-service source and takes the next winner on the same edge. With nothing in service it has no effect.
- R9: The configuration word at 0x41030 stores and reads back all 32 bits. Unused addresses read zero, and writes to them change nothing.
- R10: Requests that arrive while another source is in service stay pending and are taken in priority order after later end-of-interrupt writes. A request line held high re-pends its source after the source is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 24 | Request lines, one per source, sampled each cycle |
| addr_i | input | 18 | Word address (byte offset divided by four) |
| wr_en_i | input | 1 | Write strobe for `wdata_i` at `addr_i` |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Interrupt line to the processor |

## Verification
The bench presents requests from sources that have priority zero and from masked sources, then unmasks them. A design that held such requests instead of dropping them would raise the interrupt late. It sends simultaneous requests with a priority tie between an external line and a timer. A design that broke the tie toward the lower source number would hand out the wrong vector first. It retires interrupts back to back and expects the next vector in the cycle right after each end-of-interrupt, which catches a design that needs an extra cycle to re-arbitrate or that loses requests arriving mid-service. It also checks that a higher-priority arrival does not preempt, that end-of-interrupt with nothing in service changes nothing, and that a held request line is taken again.

// File: rtl/irq_prio_pkg.sv
// Shared constants, field layout and address map of the interrupt controller.
// Assumes the word address equals the byte offset divided by four.
package irq_prio_pkg;

    localparam int PRIO_W = 4;
    localparam int VEC_W  = 8;

    // bit positions in a source's vector/priority word
    localparam int MASK_BIT = 31;
    localparam int ACT_BIT  = 30;
    localparam int PRIO_LSB = 16;
    localparam int VEC_LSB  = 0;

    // word addresses
    localparam int unsigned LIN_VP_W     = 32'h14080;
    localparam int unsigned LIN_STRIDE_W = 8;
    localparam int unsigned TMR_VP_W     = 32'h10448;
    localparam int unsigned TMR_STRIDE_W = 16;
    localparam int unsigned DST_OFF_W    = 4;
    localparam int unsigned CFG_W        = 32'h1040C;
    localparam int unsigned SPUR_W       = 32'h10438;
    localparam int unsigned ACK_W        = 32'h18028;
    localparam int unsigned EOI_W        = 32'h1802C;

    typedef struct packed {
        logic              mask;
        logic [PRIO_W-1:0] prio;
        logic [VEC_W-1:0]  vec;
        logic              dest;
    } src_cfg_t;

    // word address of source idx's vector/priority register
    function automatic int unsigned vp_word(input int unsigned idx, input int unsigned n_lin);
        if (idx < n_lin)
            return LIN_VP_W + idx * LIN_STRIDE_W;
        else
            return TMR_VP_W + (idx - n_lin) * TMR_STRIDE_W;
    endfunction

endpackage

// File: rtl/irq_src_slot.sv
// One interrupt source: its configuration and its pending flag.
// Assumes the write strobes are already address-decoded and one-hot at most.
module irq_src_slot
    import irq_prio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_vp_i,
    input  logic              wr_dst_i,
    input  logic              mask_d_i,
    input  logic [PRIO_W-1:0] prio_d_i,
    input  logic [VEC_W-1:0]  vec_d_i,
    input  logic              dest_d_i,
    input  logic              req_i,
    input  logic              take_i,
    output src_cfg_t          cfg_o,
    output logic              pend_o
);

    logic accept;
    assign accept = req_i && !cfg_o.mask && (cfg_o.prio != '0);

    // configuration storage; reset leaves the source masked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o <= '{mask: 1'b1, prio: '0, vec: '0, dest: 1'b0};
        end else begin
            if (wr_vp_i) begin
                cfg_o.mask <= mask_d_i;
                cfg_o.prio <= prio_d_i;
                cfg_o.vec  <= vec_d_i;
            end
            if (wr_dst_i)
                cfg_o.dest <= dest_d_i;
        end
    end

    // pending flag: cleared on take, then set by an accepted request
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_o <= 1'b0;
        else
            pend_o <= (pend_o && !take_i) || accept;
    end

    // R4
    pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_o) |-> $past(req_i && !cfg_o.mask && (cfg_o.prio != '0)));

    // R2
    vp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vp_i |=> (cfg_o.prio == $past(prio_d_i)) && (cfg_o.vec == $past(vec_d_i))
                    && (cfg_o.mask == $past(mask_d_i)));

endmodule

// File: rtl/irq_arbiter.sv
// Combinational selection of the winning pending source.
// Highest priority wins; on equal priority the higher index wins.
module irq_arbiter
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC = 24,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]             pend_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    output logic                           any_o,
    output logic [IDX_W-1:0]               win_o
);

    logic [PRIO_W-1:0] best;

    // ascending scan with >= so later (higher) indices win ties
    always_comb begin
        any_o = 1'b0;
        win_o = '0;
        best  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend_i[i] && (!any_o || prio_i[i] >= best)) begin
                any_o = 1'b1;
                win_o = IDX_W'(i);
                best  = prio_i[i];
            end
        end
    end

endmodule

// File: rtl/irq_service.sv
// In-service tracking: takes the winner when free, latches its vector,
// drives the processor line, and retires on end-of-interrupt.
// Assumes one processor and no nesting.
module irq_service
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC = 24,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               any_i,
    input  logic [IDX_W-1:0]   win_i,
    input  logic [VEC_W-1:0]   win_vec_i,
    input  logic               eoi_i,
    output logic [NUM_SRC-1:0] take_o,
    output logic [NUM_SRC-1:0] active_o,
    output logic               in_svc_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic               irq_o
);

    logic [IDX_W-1:0] act_idx;
    logic             take;

    assign take   = (!in_svc_o || eoi_i) && any_i;
    assign take_o = take ? (NUM_SRC'(1) << win_i) : '0;

    // retire on end-of-interrupt, then take the next winner on the same edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= '0;
            in_svc_o <= 1'b0;
            act_idx  <= '0;
            vec_o    <= '0;
            irq_o    <= 1'b0;
        end else begin
            if (eoi_i && in_svc_o) begin
                active_o[act_idx] <= 1'b0;
                in_svc_o          <= 1'b0;
                irq_o             <= 1'b0;
            end
            if (take) begin
                active_o[win_i] <= 1'b1;
                in_svc_o        <= 1'b1;
                act_idx         <= win_i;
                vec_o           <= win_vec_i;
                irq_o           <= 1'b1;
            end
        end
    end

    // R6
    single_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(active_o));

    // R6
    irq_tracks_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (active_o != '0));

    // R6
    no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_svc_o && !eoi_i) |=> in_svc_o && $stable(vec_o) && $stable(active_o));

endmodule

// File: rtl/irq_prio_ctrl.sv
// Top of the vectored priority interrupt controller: register decode,
// read multiplexer, per-source slots, arbiter and service tracker.
// Assumes a word-addressed 32-bit bus with combinational, side-effect-free reads.
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_LIN = 20,
    parameter int NUM_TMR = 4,
    parameter int ADDR_W  = 18,
    parameter int DATA_W  = 32,
    localparam int NUM_SRC = NUM_LIN + NUM_TMR,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               irq_o
);

    localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_W);
    localparam logic [ADDR_W-1:0] SPUR_A = ADDR_W'(SPUR_W);
    localparam logic [ADDR_W-1:0] ACK_A  = ADDR_W'(ACK_W);
    localparam logic [ADDR_W-1:0] EOI_A  = ADDR_W'(EOI_W);

    src_cfg_t                      cfg [NUM_SRC];
    logic [NUM_SRC-1:0]            vp_hit, dst_hit, pend, take, active;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_arr;
    logic [NUM_SRC-1:0][VEC_W-1:0]  vec_arr;
    logic                          any_pend, in_svc, eoi_wr;
    logic [IDX_W-1:0]              win;
    logic [VEC_W-1:0]              ack_vec, spur_q;
    logic [DATA_W-1:0]             cfg_q;

    assign eoi_wr = wr_en_i && (addr_i == EOI_A);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        localparam int unsigned VPW = vp_word(g, NUM_LIN);

        assign vp_hit[g]  = (addr_i == ADDR_W'(VPW));
        assign dst_hit[g] = (addr_i == ADDR_W'(VPW + DST_OFF_W));

        irq_src_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_vp_i  (wr_en_i && vp_hit[g]),
            .wr_dst_i (wr_en_i && dst_hit[g]),
            .mask_d_i (wdata_i[MASK_BIT]),
            .prio_d_i (wdata_i[PRIO_LSB +: PRIO_W]),
            .vec_d_i  (wdata_i[VEC_LSB +: VEC_W]),
            .dest_d_i (wdata_i[0]),
            .req_i    (req_i[g]),
            .take_i   (take[g]),
            .cfg_o    (cfg[g]),
            .pend_o   (pend[g])
        );

        assign prio_arr[g] = cfg[g].prio;
        assign vec_arr[g]  = cfg[g].vec;
    end

    irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .pend_i (pend),
        .prio_i (prio_arr),
        .any_o  (any_pend),
        .win_o  (win)
    );

    irq_service #(.NUM_SRC(NUM_SRC)) u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_i     (any_pend),
        .win_i     (win),
        .win_vec_i (vec_arr[win]),
        .eoi_i     (eoi_wr),
        .take_o    (take),
        .active_o  (active),
        .in_svc_o  (in_svc),
        .vec_o     (ack_vec),
        .irq_o     (irq_o)
    );

    // global registers: configuration word and spurious vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            spur_q <= '0;
        end else if (wr_en_i) begin
            if (addr_i == CFG_A)
                cfg_q <= wdata_i;
            if (addr_i == SPUR_A)
                spur_q <= wdata_i[VEC_W-1:0];
        end
    end

    // read multiplexer; unmatched addresses return zero
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (vp_hit[i]) begin
                rdata_o[MASK_BIT]                 = cfg[i].mask;
                rdata_o[ACT_BIT]                  = active[i];
                rdata_o[PRIO_LSB +: PRIO_W]       = cfg[i].prio;
                rdata_o[VEC_LSB +: VEC_W]         = cfg[i].vec;
            end
            if (dst_hit[i])
                rdata_o[0] = cfg[i].dest;
        end
        if (addr_i == CFG_A)
            rdata_o = cfg_q;
        if (addr_i == SPUR_A)
            rdata_o[VEC_W-1:0] = spur_q;
        if (addr_i == ACK_A)
            rdata_o[VEC_W-1:0] = in_svc ? ack_vec : spur_q;
    end

    // R8
    eoi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && irq_o && !any_pend) |=> !irq_o);

    // R7
    ack_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && addr_i == ACK_A) |-> rdata_o == DATA_W'(spur_q));

endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] req = '0;
    logic [17:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    logic [31:0] v;

    always #10 clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .addr_i  (addr),
        .wr_en_i (wr_en),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] d;
        logic [31:0] e;
    } vec_t;

    // write, then read back the same byte offset
    localparam vec_t TBL [10] = '{
        '{32'h50200, 32'h400500AB, 32'h000500AB},  // R2 active bit read-only
        '{32'h503E0, 32'hFFFFFFFF, 32'h800F00FF},  // R2 unused bits zero
        '{32'h50270, 32'hFFFFFFFF, 32'h00000001},  // R3 ext3 destination
        '{32'h411A0, 32'h00030042, 32'h00030042},  // R3 timer2 vp
        '{32'h411F0, 32'h00000002, 32'h00000000},  // R2 destination bit0 only
        '{32'h410E0, 32'h123456FF, 32'h000000FF},  // R7 spurious 8 bits
        '{32'h41030, 32'h12345678, 32'h12345678},  // R9 config word
        '{32'h50204, 32'h0000DEAD, 32'h00000000},  // R9 unused address
        '{32'h50460, 32'h00010013, 32'h00010013},  // R3 message unit
        '{32'h50410, 32'h00000001, 32'h00000001}   // R3 I2C destination
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int unsigned ba, input logic [31:0] d);
        @(negedge clk);
        addr  = 18'(ba >> 2);
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int unsigned ba, output logic [31:0] d);
        addr = 18'(ba >> 2);
        #1;
        d = rdata;
    endtask

    // present a one-cycle request, then wait until it can have been taken
    task automatic pulse(input logic [23:0] m);
        @(negedge clk);
        req = m;
        @(negedge clk);
        req = '0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req   = '0;
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();

        // R1 reset state
        chk("R1 irq low", 32'(irq), 32'd0);
        rd(32'h502A0, v); chk("R1 ext5 masked", v, 32'h80000000);
        rd(32'h41160, v); chk("R1 timer1 masked", v, 32'h80000000);
        rd(32'h600A0, v); chk("R1 ack spurious zero", v, 32'h0);

        // R2 R3 R9 table walk
        for (int k = 0; k < 10; k++) begin
            wr(TBL[k].a, TBL[k].d);
            rd(TBL[k].a, v);
            chk($sformatf("R2 R3 R9 table entry %0d", k), v, TBL[k].e);
        end
        rd(32'h50200, v); chk("R9 unused write left neighbour", v, 32'h000500AB);

        // R4 dropped requests
        do_reset();
        wr(32'h50240, 32'h00000022);
        wr(32'h50280, 32'h80050044);
        pulse(24'h000014);
        chk("R4 prio zero or masked dropped", 32'(irq), 32'd0);
        wr(32'h50280, 32'h00050044);
        repeat (2) @(negedge clk);
        chk("R4 unmask does not revive", 32'(irq), 32'd0);
        pulse(24'h000010);
        chk("R4 accepted request raises irq", 32'(irq), 32'd1);
        rd(32'h600A0, v); chk("R4 ack vector", v, 32'h44);

        // R5 R6 R7 R8 R10 arbitration and retirement
        do_reset();
        wr(32'h410E0, 32'h0000005A);
        wr(32'h50220, 32'h00030011);
        wr(32'h502C0, 32'h00070066);
        wr(32'h41120, 32'h000700A0);
        wr(32'h50320, 32'h00020099);
        pulse(24'h100242);
        chk("R6 irq raised", 32'(irq), 32'd1);
        rd(32'h600A0, v); chk("R5 tie to higher source", v, 32'hA0);
        rd(32'h41120, v); chk("R2 active flag set", v, 32'h400700A0);
        rd(32'h502C0, v); chk("R2 waiting source not active", v, 32'h00070066);
        wr(32'h600B0, 32'h0);
        rd(32'h600A0, v); chk("R8 next taken at eoi edge", v, 32'h66);
        rd(32'h41120, v); chk("R8 active cleared", v, 32'h000700A0);
        wr(32'h600B0, 32'h0);
        rd(32'h600A0, v); chk("R10 held request", v, 32'h11);
        pulse(24'h100000);
        rd(32'h600A0, v); chk("R6 no preemption", v, 32'h11);
        wr(32'h600B0, 32'h0);
        rd(32'h600A0, v); chk("R10 mid-service arrival taken", v, 32'hA0);
        wr(32'h600B0, 32'h0);
        rd(32'h600A0, v); chk("R5 lowest priority last", v, 32'h99);
        wr(32'h600B0, 32'h0);
        chk("R6 irq low when idle", 32'(irq), 32'd0);
        rd(32'h600A0, v); chk("R7 spurious when idle", v, 32'h5A);
        wr(32'h600B0, 32'h0);
        chk("R8 idle eoi no effect irq", 32'(irq), 32'd0);
        rd(32'h50320, v); chk("R8 idle eoi no effect state", v, 32'h00020099);

        // R10 level request
        do_reset();
        wr(32'h50260, 32'h00040033);
        @(negedge clk);
        req[3] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 level taken", 32'(irq), 32'd1);
        rd(32'h600A0, v); chk("R10 level vector", v, 32'h33);
        wr(32'h600B0, 32'h0);
        chk("R10 level retaken", 32'(irq), 32'd1);
        rd(32'h50260, v); chk("R10 retaken active", v, 32'h40040033);
        req[3] = 1'b0;
        wr(32'h600B0, 32'h0);
        chk("R10 pending kept after release", 32'(irq), 32'd1);
        wr(32'h600B0, 32'h0);
        chk("R10 drained", 32'(irq), 32'd0);

        // R1 reset in the middle of service
        wr(32'h50260, 32'h00040033);
        pulse(24'h000008);
        do_reset();
        chk("R1 reset clears service", 32'(irq), 32'd0);
        rd(32'h50260, v); chk("R1 reset masks source", v, 32'h80000000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule